// File: doc/BRIEF.md
# Receive Byte Queue with Break Insertion

This block is a four-entry byte queue between a receive byte source and a register bank. Bytes arrive on a valid/ready stream. The queue stores them in arrival order and presents the oldest one at its head for the bus to read. A pop strobe removes the head. The queue also reports how many bytes are stored and how many slots the source may still fill.

A break event from the line pushes a zero byte into the queue and raises a one-cycle break-change pulse for the interrupt logic. Unlike ordinary data, a break is never refused. When the queue is full, the break replaces the newest stored byte.

The incoming stream follows these back-pressure rules. A byte is taken only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is combinational from the current state and the same cycle's `rx_en`, `flush`, `brk_evt` and `pop`. A byte offered while `in_ready` is low is neither stored nor queued anywhere else. The source may hold it or drop it.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset, count is 0, `rx_ready`, `rx_full` and `brk_pulse` are 0, and `head_data` is 0x00.
- R2: `free_slots` equals 4 minus count while `rx_en` is high and 0 while it is low. `in_ready` is high exactly when `rx_en` is high, `flush` and `brk_evt` are low, and the count after this cycle's pop is below 4.
- R3: A data byte offered while `in_ready` is low (receiver disabled or queue full) is not stored, and the count does not change.
- R4: Bytes leave in arrival order. `head_data` shows the oldest stored byte in the same cycle, and a pop removes it at the next clock edge.
- R5: A pop while the queue is empty leaves the count and flags unchanged, and `head_data` reads 0x00.
- R6: A break event stores a zero byte even while `rx_en` is low, and `brk_pulse` is high for exactly the following cycle. A data byte is not taken in the same cycle as a break.
- R7: A break arriving on a full queue with no pop overwrites the newest entry with 0x00. The count stays at 4, and the older three bytes are kept in order.
- R8: A pop and a data push in the same cycle apply the pop first, so a full queue accepts the new byte and still holds 4 entries.
- R9: `rx_ready` is high exactly when count is nonzero. `rx_full` is high exactly when count is 4, so any pop from a full queue without a refill clears it.
- R10: `flush` empties the queue and clears `rx_ready` and `rx_full` at the next edge. A byte or break offered in the same cycle is discarded, though the break pulse still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming byte valid |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Queue takes the byte this cycle |
| brk_evt | input | 1 | Line break detected (one cycle per event) |
| pop | input | 1 | Remove the head byte |
| flush | input | 1 | Empty the queue |
| rx_en | input | 1 | Receiver enable |
| head_data | output | 8 | Oldest stored byte, 0x00 when empty |
| count | output | 3 | Number of stored bytes |
| free_slots | output | 3 | Slots the source may fill |
| rx_ready | output | 1 | At least one byte stored |
| rx_full | output | 1 | Queue holds four bytes |
| brk_pulse | output | 1 | One-cycle break-change pulse |

## Verification
The outputs fall into two timing groups:
- `in_ready`, `free_slots` and `head_data` are combinational and are due in the same cycle as the inputs that shape them.
- `count`, `rx_ready`, `rx_full` and `brk_pulse` are registered and change one clock edge after the stimulus.

The bench drives every input on the falling edge and checks the combinational group 1 ns later. It then advances its queue-based reference model at the rising edge and checks the registered group at the next falling edge. Every cycle, directed or random, is compared this way. Extra directed checks target overwrite-on-break, pop-with-push at full, empty pops and flush.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_APPEND  = 2'd1,
    WR_REPLACE = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             brk_evt,
  input  logic             pop,
  input  logic             flush,
  input  logic             rx_en,
  output logic             in_ready,
  output logic             pop_go,
  output wr_kind_e         wr_kind,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] free_slots
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] after_pop;
  logic             room;

  always_comb begin
    pop_go    = pop && (cnt != '0) && !flush;
    after_pop = cnt - CNT_W'(pop_go);
    room      = after_pop < FULL_CNT;
    in_ready  = rx_en && !flush && !brk_evt && room;
    if (flush)                     wr_kind = WR_NONE;
    else if (brk_evt)              wr_kind = room ? WR_APPEND : WR_REPLACE;
    else if (in_valid && in_ready) wr_kind = WR_APPEND;
    else                           wr_kind = WR_NONE;
    cnt_nxt    = flush ? '0 : after_pop + CNT_W'(wr_kind == WR_APPEND);
    free_slots = rx_en ? (FULL_CNT - cnt) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  a_r3_no_take_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !in_ready);

  a_r7_break_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_evt && !flush && !pop && cnt == FULL_CNT) |=> (cnt == FULL_CNT));

  a_r5_empty_pop_still: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt == '0 && !brk_evt && !flush && !(in_valid && in_ready)) |=> (cnt == '0));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_kind_e         wr_kind,
  input  logic [W-1:0]     wr_data,
  input  logic             pop_go,
  input  logic             flush,
  input  logic [CNT_W-1:0] cnt,
  output logic [W-1:0]     head_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, wr_idx;
  logic             wr_en;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - PTR_W'(1);
  endfunction

  always_comb begin
    wr_en     = (wr_kind != WR_NONE);
    wr_idx    = (wr_kind == WR_REPLACE) ? ptr_dec(wr_ptr) : wr_ptr;
    head_data = (cnt == '0) ? '0 : slot[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      if (pop_go) rd_ptr <= ptr_inc(rd_ptr);
      if (wr_kind == WR_APPEND) wr_ptr <= ptr_inc(wr_ptr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[i] <= '0;
      else if (wr_en && wr_idx == PTR_W'(i)) slot[i] <= wr_data;
    end
  end

  a_r5_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (head_data == '0));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cnt,
  input  logic             brk_evt,
  output logic             rx_ready,
  output logic             rx_full,
  output logic             brk_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready  <= 1'b0;
      rx_full   <= 1'b0;
      brk_pulse <= 1'b0;
    end else begin
      rx_ready  <= (cnt_nxt != '0);
      rx_full   <= (cnt_nxt == CNT_W'(DEPTH));
      brk_pulse <= brk_evt;
    end
  end

  a_r9_ready_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready == (cnt != '0));

  a_r9_full_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full == (cnt == CNT_W'(DEPTH)));

  a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pulse && !$past(brk_evt, 2)) |=> (brk_pulse == $past(brk_evt)));
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_data,
  output logic             in_ready,
  input  logic             brk_evt,
  input  logic             pop,
  input  logic             flush,
  input  logic             rx_en,
  output logic [W-1:0]     head_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] free_slots,
  output logic             rx_ready,
  output logic             rx_full,
  output logic             brk_pulse
);
  wr_kind_e         wr_kind;
  logic             pop_go;
  logic [CNT_W-1:0] cnt_nxt;
  logic [W-1:0]     wr_data;

  assign wr_data = brk_evt ? '0 : in_data;

  rxq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .brk_evt(brk_evt),
    .pop(pop), .flush(flush), .rx_en(rx_en), .in_ready(in_ready),
    .pop_go(pop_go), .wr_kind(wr_kind), .cnt(count), .cnt_nxt(cnt_nxt),
    .free_slots(free_slots)
  );

  rxq_store #(.DEPTH(DEPTH), .W(W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_kind(wr_kind), .wr_data(wr_data),
    .pop_go(pop_go), .flush(flush), .cnt(count), .head_data(head_data)
  );

  rxq_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .cnt(count),
    .brk_evt(brk_evt), .rx_ready(rx_ready), .rx_full(rx_full),
    .brk_pulse(brk_pulse)
  );

  a_r2_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slots + count) <= CNT_W'(DEPTH));
endmodule

// File: tb/rx_byte_queue_test.sv
`timescale 1ns/1ps
module rx_byte_queue_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, brk_evt, pop, flush, rx_en;
  logic [7:0] in_data;
  logic       in_ready, rx_ready, rx_full, brk_pulse;
  logic [7:0] head_data;
  logic [2:0] count, free_slots;

  int total = 0;
  int bad = 0;
  logic [7:0] q[$];
  bit exp_pulse = 0;

  always #4 clk = ~clk;

  rx_byte_queue uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .brk_evt(brk_evt), .pop(pop), .flush(flush),
    .rx_en(rx_en), .head_data(head_data), .count(count),
    .free_slots(free_slots), .rx_ready(rx_ready), .rx_full(rx_full),
    .brk_pulse(brk_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] d, input bit b,
                      input bit p, input bit f, input bit e);
    bit rdy;
    in_valid = v; in_data = d; brk_evt = b; pop = p; flush = f; rx_en = e;
    #1;
    rdy = e && !f && !b && ((q.size() < 4) || (p && q.size() > 0));
    chk("R2 in_ready", in_ready, rdy);
    chk("R2 free_slots", free_slots, e ? 4 - q.size() : 0);
    chk("R4 head_data", head_data, q.size() > 0 ? q[0] : 0);
    @(posedge clk);
    if (f) q.delete();
    else begin
      if (p && q.size() > 0) void'(q.pop_front());
      if (b) begin
        if (q.size() == 4) q[3] = 8'h00;
        else q.push_back(8'h00);
      end else if (v && rdy) q.push_back(d);
    end
    exp_pulse = b;
    @(negedge clk);
    chk("R4 count", count, q.size());
    chk("R9 rx_ready", rx_ready, q.size() != 0);
    chk("R9 rx_full", rx_full, q.size() == 4);
    chk("R6 brk_pulse", brk_pulse, exp_pulse);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; in_data = 0; brk_evt = 0; pop = 0; flush = 0; rx_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 brk_pulse", brk_pulse, 0);
    chk("R1 head_data", head_data, 0);

    // R3: disabled receiver ignores data
    step(1, 8'hA5, 0, 0, 0, 0);
    chk("R3 disabled push ignored", count, 0);

    // R4: fill in order
    step(1, 8'h11, 0, 0, 0, 1);
    step(1, 8'h22, 0, 0, 0, 1);
    step(1, 8'h33, 0, 0, 0, 1);
    step(1, 8'h44, 0, 0, 0, 1);
    chk("R4 oldest at head", head_data, 8'h11);
    // R3: full queue refuses data
    step(1, 8'h55, 0, 0, 0, 1);
    chk("R3 full push ignored count", count, 4);
    // R7: break on full overwrites newest
    step(0, 8'h00, 1, 0, 0, 1);
    chk("R7 break overwrite count", count, 4);
    chk("R7 overwrite keeps head", head_data, 8'h11);
    // R8: pop with push on full
    step(1, 8'h66, 0, 1, 0, 1);
    chk("R8 pop+push count", count, 4);
    chk("R8 new head", head_data, 8'h22);
    step(0, 0, 0, 1, 0, 1);
    step(0, 0, 0, 1, 0, 1);
    chk("R7 zero byte at newest-1 slot", head_data, 8'h00);
    step(0, 0, 0, 1, 0, 1);
    chk("R8 pushed byte last", head_data, 8'h66);
    step(0, 0, 0, 1, 0, 1);
    // R5: pop on empty
    step(0, 0, 0, 1, 0, 1);
    chk("R5 empty pop count", count, 0);
    chk("R5 empty head zero", head_data, 0);
    // R6: break while disabled
    step(1, 8'h77, 1, 0, 0, 0);
    chk("R6 break when disabled count", count, 1);
    chk("R6 break byte zero", head_data, 0);
    chk("R6 pulse", brk_pulse, 1);
    step(0, 0, 0, 0, 0, 1);
    chk("R6 pulse ends", brk_pulse, 0);
    // R10: flush discards same-cycle push and break
    step(1, 8'h12, 0, 0, 0, 1);
    step(1, 8'h34, 1, 0, 1, 1);
    chk("R10 flush count", count, 0);
    chk("R10 flush rx_ready", rx_ready, 0);
    chk("R10 flush pulse still fires", brk_pulse, 1);

    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 3) != 0, 8'($urandom), $urandom_range(0, 15) == 0,
           $urandom_range(0, 2) == 0, $urandom_range(0, 40) == 0,
           $urandom_range(0, 7) != 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule